// File: doc/BRIEF.md
# Split-Phase Register File Front End

This block supplies the two source operands of a pipelined datapath from a register file. The register file is built from single-ported storage, and the block still completes one write and one set of operand reads in every clock period. The clock's two phases share the storage. The incoming result and its destination index are first held in a write-back register. The storage takes that write at the falling edge. During the low phase it is read at the two source indices, so each read already sees the value written in the same period.

Each read value then passes a select stage before it reaches an operand register on the next rising edge. The second operand may be replaced by an immediate. Either operand may take the value held in the write-back register when its index matches and forwarding is enabled. Each of the two operands is read from its own copy of the storage. Both copies are written together.

Top module: `sp_regfile_front`

## Requirements
- R1: While rst_ni is low, both op_a_o and op_b_o are zero, and no write to the register file is pending.
- R2: A result presented with res_we_i=1 in cycle k is captured at the rising edge that ends cycle k. Source indices presented in cycle k+1 or later read that value. The operands appear on op_a_o/op_b_o after the rising edge that ends the cycle in which the indices were presented.
- R3: A source index presented in the same cycle as a result to that index reads the register's previous content.
- R4: Index 0 always reads as zero. A result written to index 0 is discarded.
- R5: A result presented with res_we_i=0 leaves every register unchanged.
- R6: op_a_o follows rs1_idx_i and op_b_o follows rs2_idx_i. The two indices are independent and may be equal.
- R7: When imm_sel_i=1, op_b_o takes imm_i regardless of rs2_idx_i and of forwarding.
- R8: imm_sel_i never affects op_a_o.
- R9: When fwd_en_i=1 and a source index equals the non-zero destination held in the write-back register with its write enable set, that operand takes the held result. This is the same value the register now reads.
- R10: The operand registers load new values on every rising edge outside reset. No stall exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both phases are used |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_we_i | input | 1 | Result write enable |
| res_idx_i | input | $clog2(REG_N) | Result destination index |
| res_data_i | input | DATA_W | Result value |
| rs1_idx_i | input | $clog2(REG_N) | First source index |
| rs2_idx_i | input | $clog2(REG_N) | Second source index |
| imm_i | input | DATA_W | Immediate value |
| imm_sel_i | input | 1 | Replace the second operand with imm_i |
| fwd_en_i | input | 1 | Allow forwarding from the write-back register |
| op_a_o | output | DATA_W | Registered first operand |
| op_b_o | output | DATA_W | Registered second operand |

## Verification
The bench builds the block with DATA_W=16 and REG_N=8. With only eight indices, random destination and source indices collide often. That brings same-cycle read-after-write, back-to-back write-then-read, index 0 and forwarding hits into reach on many cycles without steering. The 16-bit width keeps immediates and results distinct from each other, so a wrong select shows up in the value.

// File: rtl/sp_rf_pkg.sv
package sp_rf_pkg;
  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_FWD  = 2'd1,
    SRC_IMM  = 2'd2,
    SRC_ZERO = 2'd3
  } src_sel_e;

  // Immediate beats forwarding, forwarding beats zero/RAM.
  function automatic src_sel_e pick_src(input logic imm_sel, input logic fwd_hit,
                                        input logic idx_zero);
    if (imm_sel)       return SRC_IMM;
    else if (fwd_hit)  return SRC_FWD;
    else if (idx_zero) return SRC_ZERO;
    else               return SRC_RAM;
  endfunction
endpackage

// File: rtl/sp_wb_stage.sv
module sp_wb_stage #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
    end else begin
      we_o   <= we_i;
      idx_o  <= idx_i;
      data_o <= data_i;
    end
  end

  p_wb_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (we_o && idx_o == $past(idx_i) && data_o == $past(data_i)));
  p_wb_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !we_o);
endmodule

// File: rtl/sp_reg_bank.sv
module sp_reg_bank #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [REG_N];

  // Write address/data are stable through the high phase; commit at the falling edge.
  always_ff @(negedge clk_i) begin
    if (we_i && wr_idx_i != '0) mem_q[wr_idx_i] <= wr_data_i;
  end

  // Read is sampled by the operand registers at the end of the low phase.
  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/sp_operand_sel.sv
module sp_operand_sel
  import sp_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  src_idx_i,
  input  logic [DATA_W-1:0] ram_data_i,
  input  logic              wb_we_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              fwd_en_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              imm_sel_i,
  output logic [DATA_W-1:0] op_o
);
  logic      fwd_hit;
  logic      idx_zero;
  src_sel_e  sel;
  logic [DATA_W-1:0] op_d;

  assign idx_zero = (src_idx_i == '0);
  assign fwd_hit  = fwd_en_i && wb_we_i && !idx_zero && (wb_idx_i == src_idx_i);
  assign sel      = pick_src(imm_sel_i, fwd_hit, idx_zero);

  always_comb begin
    unique case (sel)
      SRC_IMM:  op_d = imm_i;
      SRC_FWD:  op_d = wb_data_i;
      SRC_ZERO: op_d = '0;
      default:  op_d = ram_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_o <= '0;
    else         op_o <= op_d;
  end

  p_imm_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_sel_i |=> op_o == $past(imm_i));
  p_zero_index_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_sel_i && src_idx_i == '0) |=> op_o == '0);
  p_fwd_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_sel_i && fwd_en_i && wb_we_i && src_idx_i != '0 && src_idx_i == wb_idx_i)
      |=> op_o == $past(wb_data_i));
  p_ram_agrees_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_sel_i && wb_we_i && src_idx_i != '0 && src_idx_i == wb_idx_i)
      |=> op_o == $past(wb_data_i));
endmodule

// File: rtl/sp_regfile_front.sv
module sp_regfile_front #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_we_i,
  input  logic [IDX_W-1:0]  res_idx_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [IDX_W-1:0]  rs1_idx_i,
  input  logic [IDX_W-1:0]  rs2_idx_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              imm_sel_i,
  input  logic              fwd_en_i,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o
);
  localparam int PORTS = 2;

  logic              wb_we;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;
  logic [IDX_W-1:0]  rd_idx  [PORTS];
  logic [DATA_W-1:0] rd_data [PORTS];
  logic [DATA_W-1:0] op      [PORTS];

  assign rd_idx[0] = rs1_idx_i;
  assign rd_idx[1] = rs2_idx_i;

  sp_wb_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_wb (
    .clk_i, .rst_ni,
    .we_i(res_we_i), .idx_i(res_idx_i), .data_i(res_data_i),
    .we_o(wb_we), .idx_o(wb_idx), .data_o(wb_data)
  );

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    // One storage copy per read port, written in lockstep.
    sp_reg_bank #(.DATA_W(DATA_W), .REG_N(REG_N)) i_bank (
      .clk_i,
      .we_i(wb_we), .wr_idx_i(wb_idx), .wr_data_i(wb_data),
      .rd_idx_i(rd_idx[g]), .rd_data_o(rd_data[g])
    );
    sp_operand_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_sel (
      .clk_i, .rst_ni,
      .src_idx_i(rd_idx[g]), .ram_data_i(rd_data[g]),
      .wb_we_i(wb_we), .wb_idx_i(wb_idx), .wb_data_i(wb_data),
      .fwd_en_i, .imm_i,
      .imm_sel_i((g == 1) ? imm_sel_i : 1'b0),
      .op_o(op[g])
    );
  end

  assign op_a_o = op[0];
  assign op_b_o = op[1];

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (op_a_o == '0 && op_b_o == '0 && !wb_we));
  p_a_ignores_imm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_sel_i && rs1_idx_i == '0) |=> op_a_o == '0);
  p_same_index_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_sel_i && rs1_idx_i == rs2_idx_i) |=> op_a_o == op_b_o);
endmodule

// File: tb/test_sp_regfile_front.sv
module test_sp_regfile_front;
  localparam int DW = 16;
  localparam int RN = 8;
  localparam int IW = $clog2(RN);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_we = 1'b0;
  logic [IW-1:0] res_idx = '0;
  logic [DW-1:0] res_data = '0;
  logic [IW-1:0] rs1 = '0;
  logic [IW-1:0] rs2 = '0;
  logic [DW-1:0] imm = '0;
  logic          imm_sel = 1'b0;
  logic          fwd_en = 1'b0;
  logic [DW-1:0] op_a, op_b;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] model [RN];
  logic          pend_we = 1'b0;
  logic [IW-1:0] pend_idx = '0;
  logic [DW-1:0] pend_data = '0;
  logic [DW-1:0] exp_a = '0, exp_b = '0;
  string         exp_tag = "";
  logic          exp_valid = 1'b0;

  always #4 clk = ~clk;

  sp_regfile_front #(.DATA_W(DW), .REG_N(RN)) i_sp_regfile_front (
    .clk_i(clk), .rst_ni(rst_n),
    .res_we_i(res_we), .res_idx_i(res_idx), .res_data_i(res_data),
    .rs1_idx_i(rs1), .rs2_idx_i(rs2), .imm_i(imm), .imm_sel_i(imm_sel),
    .fwd_en_i(fwd_en), .op_a_o(op_a), .op_b_o(op_b)
  );

  function automatic logic [DW-1:0] rd(input logic [IW-1:0] i);
    return (i == '0) ? '0 : model[i];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [IW-1:0] di,
                      input logic [DW-1:0] dd, input logic [IW-1:0] s1, input logic [IW-1:0] s2,
                      input logic [DW-1:0] im, input logic isel, input logic fe);
    @(posedge clk);
    #1;
    if (exp_valid) begin
      check({exp_tag, " op_a"}, op_a, exp_a);
      check({exp_tag, " op_b"}, op_b, exp_b);
    end
    if (pend_we && pend_idx != '0) model[pend_idx] = pend_data;
    res_we = we; res_idx = di; res_data = dd;
    rs1 = s1; rs2 = s2; imm = im; imm_sel = isel; fwd_en = fe;
    exp_a = rd(s1);
    exp_b = isel ? im : rd(s2);
    exp_tag = tag;
    exp_valid = 1'b1;
    pend_we = we; pend_idx = di; pend_data = dd;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < RN; i++) model[i] = '0;
    void'($urandom(32'd1234));
    // R1: reset state
    #13;
    check("R1 op_a in reset", op_a, '0);
    check("R1 op_b in reset", op_b, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill registers, reading index 0 only.
    for (int i = 1; i < RN; i++)
      step("R4 r0 during fill", 1'b1, IW'(i), DW'(16'h1000 + i), '0, '0, '0, 1'b0, 1'b0);
    step("R2 fill drain", 1'b0, '0, '0, '0, '0, '0, 1'b0, 1'b0);

    // R2: back-to-back write then read
    step("R2 write r3", 1'b1, 3'd3, 16'hBEEF, 3'd1, 3'd2, '0, 1'b0, 1'b0);
    step("R2 read r3 next cycle", 1'b0, '0, '0, 3'd3, 3'd3, '0, 1'b0, 1'b0);
    // R3: same-cycle read sees old content
    step("R3 read during write r5", 1'b1, 3'd5, 16'h5A5A, 3'd5, 3'd5, '0, 1'b0, 1'b0);
    // R9: forward from write-back register
    step("R9 forward r5", 1'b0, '0, '0, 3'd5, 3'd5, '0, 1'b0, 1'b1);
    // R4: write to index 0 ignored
    step("R4 write r0", 1'b1, 3'd0, 16'hFFFF, 3'd0, 3'd0, '0, 1'b0, 1'b1);
    step("R4 read r0 after write", 1'b0, '0, '0, 3'd0, 3'd0, '0, 1'b0, 1'b1);
    // R5: disabled write
    step("R5 write disabled r6", 1'b0, 3'd6, 16'h0BAD, 3'd6, 3'd6, '0, 1'b0, 1'b0);
    step("R5 r6 unchanged", 1'b0, '0, '0, 3'd6, 3'd6, '0, 1'b0, 1'b1);
    // R7/R8: immediate wins on b, not on a, even with forwarding hit
    step("R7 write r2", 1'b1, 3'd2, 16'h2222, 3'd1, 3'd1, '0, 1'b0, 1'b0);
    step("R7 imm over fwd", 1'b0, '0, '0, 3'd2, 3'd2, 16'h7777, 1'b1, 1'b1);
    step("R8 op_a with imm_sel", 1'b0, '0, '0, 3'd4, 3'd7, 16'h1234, 1'b1, 1'b0);
    // R6: distinct and equal indices
    step("R6 distinct indices", 1'b0, '0, '0, 3'd1, 3'd7, '0, 1'b0, 1'b0);

    // R10: random traffic, fresh operands each cycle
    for (int n = 0; n < 600; n++) begin
      automatic logic          we = 1'($urandom);
      automatic logic [IW-1:0] di = IW'($urandom);
      automatic logic [DW-1:0] dd = DW'($urandom);
      automatic logic [IW-1:0] s1 = IW'($urandom);
      automatic logic [IW-1:0] s2 = IW'($urandom);
      automatic logic [DW-1:0] im = DW'($urandom);
      automatic logic          is = ($urandom % 4) == 0;
      automatic logic          fe = 1'($urandom);
      step("R10 random R6", we, di, dd, s1, s2, im, is, fe);
    end
    step("R10 drain", 1'b0, '0, '0, '0, '0, '0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule